// File: doc/BRIEF.md
# ADC Sample Sequencer Result Queue Bank

This block holds conversion results for a converter that runs several sample sequencers. It keeps one small circular queue per sequencer: a sequencer pushes a result word into the queue selected by an index, and the processor side pops the oldest word from a queue it selects. A pushed word can be read out in order even after both pointers have wrapped.

Each queue publishes a packed 16-bit state word. It carries the read pointer, the write pointer, an empty flag and a full flag, so software can see the fill level without popping. Two shared sticky status vectors, one bit per queue, record misuse. The overflow vector records a push into a full queue, and that push is dropped. The underflow vector records a pop from an empty queue, and that pop is ignored. Software clears either vector by writing ones into it.

Every port is synchronous to `clk`. Reset is asserted asynchronously and is released in step with the clock.

Top module: `smpq_fifo_bank`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, every state word reads 0x0100, both status vectors read zero and `pop_data_vld` is low.
- R2: State word layout for queue n: bits 3:0 hold the read pointer, bits 7:4 the write pointer, bit 8 the empty flag and bit 12 the full flag. All other bits are zero.
- R3: A push into a queue that is not full stores the word and advances the write pointer modulo 16. It also clears empty, and it sets full when the write pointer reaches the read pointer.
- R4: A pop from a queue that is not empty advances the read pointer modulo 16 and clears full. It sets empty when the read pointer reaches the write pointer. One cycle later `pop_data` carries the oldest stored word, with `pop_data_vld` high.
- R5: A pop from empty queue n sets bit n of `unf_flags`, leaves both pointers unchanged and keeps `pop_data_vld` low.
- R6: A push into full queue n sets bit n of `ovf_flags`, drops the word and leaves the pointers and the stored contents unchanged.
- R7: A one on bit n of `ovf_clr` or `unf_clr` clears that status bit. A new event on the same bit in the same cycle wins over the clear.
- R8: The queues are independent: an operation on one queue changes no other queue's state word or status bit.
- R9: A push and a pop on the same queue in one cycle are each judged on that queue's flags from before the cycle. Both proceed when the queue is neither empty nor full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Push request |
| push_sel | input | 2 | Queue index for the push |
| push_data | input | 12 | Result word to store |
| pop_en | input | 1 | Pop request |
| pop_sel | input | 2 | Queue index for the pop |
| ovf_clr | input | 4 | Write-one-to-clear mask for overflow bits |
| unf_clr | input | 4 | Write-one-to-clear mask for underflow bits |
| pop_data | output | 12 | Word read by the last accepted pop |
| pop_data_vld | output | 1 | `pop_data` holds a word from the previous cycle's pop |
| state_words | output | 64 | Packed state words, queue n at bits 16n+15:16n |
| ovf_flags | output | 4 | Sticky overflow bits, one per queue |
| unf_flags | output | 4 | Sticky underflow bits, one per queue |

## Verification
A request or clear mask is sampled at a rising edge. The state words and status bits show its effect one cycle later, and so do `pop_data` and `pop_data_vld`, because every output comes straight from a register. The bench drives each request on a falling edge, waits for the next rising edge, and samples 1 ns after it. At that point it compares all four state words, both status vectors and the pop outputs against its own pointer-and-count model of the queues. Each request stays on its inputs for exactly one sampling edge and is then removed.

// File: rtl/smpq_pkg.sv
package smpq_pkg;
  // state word field positions (decoded by software)
  localparam int SW_W      = 16;
  localparam int SW_TAIL_LO = 0;
  localparam int SW_HEAD_LO = 4;
  localparam int SW_PTR_W  = 4;
  localparam int SW_EMPTY  = 8;
  localparam int SW_FULL   = 12;

  function automatic logic [SW_W-1:0] pack_state(
    input logic [SW_PTR_W-1:0] tail,
    input logic [SW_PTR_W-1:0] head,
    input logic empty,
    input logic full);
    logic [SW_W-1:0] w;
    w = '0;
    w[SW_TAIL_LO +: SW_PTR_W] = tail;
    w[SW_HEAD_LO +: SW_PTR_W] = head;
    w[SW_EMPTY] = empty;
    w[SW_FULL]  = full;
    return w;
  endfunction
endpackage

// File: rtl/smpq_rst_sync.sv
module smpq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/smpq_lane.sv
module smpq_lane
  import smpq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              pop_ok_o,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              ovf_evt_o,
  output logic              unf_evt_o,
  output logic [SW_W-1:0]   state_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [PW-1:0] head_inc, tail_inc;
  logic empty_q, empty_d, full_q, full_d;
  logic push_ok, pop_ok;

  assign push_ok  = push_i & ~full_q;
  assign pop_ok   = pop_i & ~empty_q;
  assign head_inc = head_q + PW'(1);
  assign tail_inc = tail_q + PW'(1);

  // next-state
  always_comb begin
    head_d  = push_ok ? head_inc : head_q;
    tail_d  = pop_ok  ? tail_inc : tail_q;
    full_d  = full_q;
    empty_d = empty_q;
    if (push_ok && !pop_ok) begin
      full_d  = (head_inc == tail_q);
      empty_d = 1'b0;
    end else if (pop_ok && !push_ok) begin
      full_d  = 1'b0;
      empty_d = (tail_inc == head_q);
    end
  end

  // pointer and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  // storage, written only on an accepted push
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[head_q] <= push_data_i;
  end

  assign pop_ok_o  = pop_ok;
  assign rd_word_o = mem_q[tail_q];
  assign ovf_evt_o = push_i & full_q;
  assign unf_evt_o = pop_i & empty_q;
  assign state_o   = pack_state(SW_PTR_W'(tail_q), SW_PTR_W'(head_q), empty_q, full_q);

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_o[SW_EMPTY] && state_o[SW_FULL]));
  // R6
  drop_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_q && !pop_i) |=> ($stable(head_q) && full_q));
  // R5
  unf_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_q) |=> $stable(tail_q));
  // R4
  pop_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_q) |=> (tail_q == $past(tail_q) + PW'(1)) && !full_q);
  // R3
  push_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_q && !pop_i) |=> !empty_q);
endmodule

// File: rtl/smpq_stat.sv
module smpq_stat #(
  parameter int NQ = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] set_i,
  input  logic [NQ-1:0] clr_i,
  output logic [NQ-1:0] flags_o
);
  logic [NQ-1:0] flags_q, flags_d;
  logic          upd_en;

  assign upd_en = |{set_i, clr_i};

  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0 && set_i == '0) |=> ((flags_o & $past(clr_i)) == '0));
endmodule

// File: rtl/smpq_rd_port.sv
module smpq_rd_port #(
  parameter int NQ     = 4,
  parameter int DATA_W = 12,
  localparam int IW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        sel_i,
  input  logic [NQ-1:0]        pop_ok_i,
  input  logic [NQ*DATA_W-1:0] words_i,
  output logic [DATA_W-1:0]    data_o,
  output logic                 vld_o
);
  logic              take;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q;

  assign take   = |pop_ok_i;
  assign data_d = words_i[sel_i*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) data_q <= data_d;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  // R4
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_ok_i));
endmodule

// File: rtl/smpq_fifo_bank.sv
module smpq_fifo_bank
  import smpq_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  localparam int IW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic [IW-1:0]      push_sel,
  input  logic [DATA_W-1:0]  push_data,
  input  logic               pop_en,
  input  logic [IW-1:0]      pop_sel,
  input  logic [NQ-1:0]      ovf_clr,
  input  logic [NQ-1:0]      unf_clr,
  output logic [DATA_W-1:0]  pop_data,
  output logic               pop_data_vld,
  output logic [NQ*SW_W-1:0] state_words,
  output logic [NQ-1:0]      ovf_flags,
  output logic [NQ-1:0]      unf_flags
);
  logic                 rst_n_s;
  logic [NQ-1:0]        pop_ok, ovf_evt, unf_evt;
  logic [NQ*DATA_W-1:0] rd_words;

  smpq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  for (genvar q = 0; q < NQ; q++) begin : g_lane
    logic lane_push, lane_pop;
    assign lane_push = push_en && (push_sel == IW'(q));
    assign lane_pop  = pop_en  && (pop_sel  == IW'(q));

    smpq_lane #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .push_i     (lane_push),
      .push_data_i(push_data),
      .pop_i      (lane_pop),
      .pop_ok_o   (pop_ok[q]),
      .rd_word_o  (rd_words[q*DATA_W +: DATA_W]),
      .ovf_evt_o  (ovf_evt[q]),
      .unf_evt_o  (unf_evt[q]),
      .state_o    (state_words[q*SW_W +: SW_W]));
  end

  smpq_stat #(.NQ(NQ)) u_ovf (
    .clk(clk), .rst_n(rst_n_s), .set_i(ovf_evt), .clr_i(ovf_clr), .flags_o(ovf_flags));

  smpq_stat #(.NQ(NQ)) u_unf (
    .clk(clk), .rst_n(rst_n_s), .set_i(unf_evt), .clr_i(unf_clr), .flags_o(unf_flags));

  smpq_rd_port #(.NQ(NQ), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n_s), .sel_i(pop_sel), .pop_ok_i(pop_ok),
    .words_i(rd_words), .data_o(pop_data), .vld_o(pop_data_vld));

  // R5
  unf_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pop_en && unf_evt != '0) |=> !pop_data_vld);
  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ovf_evt != '0) |=> ((ovf_flags & $past(ovf_evt)) == $past(ovf_evt)));
  // R8
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(ovf_evt) && $onehot0(unf_evt));
endmodule

// File: tb/tb_smpq_fifo_bank.sv
`timescale 1ns/1ps
module tb_smpq_fifo_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_en, pop_en;
  logic [1:0]  push_sel, pop_sel;
  logic [11:0] push_data;
  logic [3:0]  ovf_clr, unf_clr;
  logic [11:0] pop_data;
  logic        pop_data_vld;
  logic [63:0] state_words;
  logic [3:0]  ovf_flags, unf_flags;

  int nchk = 0, nbad = 0;
  bit done = 0;

  // reference model from the requirements
  logic [11:0] mm [4][16];
  int mh[4], mt[4], mc[4];
  logic [3:0] m_ovf, m_unf;
  bit m_vld;
  logic [11:0] m_data;

  always #2 clk = ~clk;

  smpq_fifo_bank dut (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_sel(push_sel),
    .push_data(push_data), .pop_en(pop_en), .pop_sel(pop_sel),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr), .pop_data(pop_data),
    .pop_data_vld(pop_data_vld), .state_words(state_words),
    .ovf_flags(ovf_flags), .unf_flags(unf_flags));

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int f);
    logic [15:0] w;
    w = '0;
    w[3:0] = 4'(mt[f]);
    w[7:4] = 4'(mh[f]);
    w[8]   = (mc[f] == 0);
    w[12]  = (mc[f] == 16);
    return w;
  endfunction

  task automatic check_all(input string tg);
    for (int f = 0; f < 4; f++)
      chk(tg, $sformatf("state%0d", f), 32'(state_words[f*16 +: 16]), 32'(exp_word(f)));
    chk(tg, "ovf", 32'(ovf_flags), 32'(m_ovf));
    chk(tg, "unf", 32'(unf_flags), 32'(m_unf));
    chk(tg, "vld", 32'(pop_data_vld), 32'(m_vld));
    if (m_vld) chk(tg, "data", 32'(pop_data), 32'(m_data));
  endtask

  task automatic cyc(input string tg, input bit pv, input int pi, input logic [11:0] pd,
                     input bit qv, input int qi, input logic [3:0] oc, input logic [3:0] uc);
    bit pok, qok;
    logic [3:0] oset, uset;
    @(negedge clk);
    push_en = pv; push_sel = 2'(pi); push_data = pd;
    pop_en = qv; pop_sel = 2'(qi); ovf_clr = oc; unf_clr = uc;
    oset = '0; uset = '0;
    pok = pv && (mc[pi] != 16);
    qok = qv && (mc[qi] != 0);
    if (pv && !pok) oset[pi] = 1'b1;
    if (qv && !qok) uset[qi] = 1'b1;
    m_vld = qok;
    if (qok) begin
      m_data = mm[qi][mt[qi]];
      mt[qi] = (mt[qi] + 1) % 16;
      mc[qi]--;
    end
    if (pok) begin
      mm[pi][mh[pi]] = pd;
      mh[pi] = (mh[pi] + 1) % 16;
      mc[pi]++;
    end
    m_ovf = (m_ovf & ~oc) | oset;
    m_unf = (m_unf & ~uc) | uset;
    @(posedge clk); #1;
    push_en = 0; pop_en = 0; ovf_clr = '0; unf_clr = '0;
    check_all(tg);
  endtask

  task automatic t_reset;
    rst_n = 0; push_en = 0; pop_en = 0; push_sel = 0; pop_sel = 0;
    push_data = 0; ovf_clr = 0; unf_clr = 0;
    for (int f = 0; f < 4; f++) begin mh[f] = 0; mt[f] = 0; mc[f] = 0; end
    m_ovf = 0; m_unf = 0; m_vld = 0; m_data = 0;
    repeat (3) @(posedge clk);
    #1 check_all("R1");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1 check_all("R1");
    chk("R2", "empty word", 32'(state_words[15:0]), 32'h0100);
  endtask

  task automatic t_basic;
    cyc("R3", 1, 0, 12'hA01, 0, 0, 0, 0);
    chk("R2", "head field", 32'(state_words[15:0]), 32'h0010);
    cyc("R3", 1, 0, 12'hA02, 0, 0, 0, 0);
    cyc("R3", 1, 0, 12'hA03, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 1, 0, 0, 0);
    chk("R4", "first out", 32'(pop_data), 32'hA01);
    cyc("R4", 0, 0, 0, 1, 0, 0, 0);
    cyc("R4", 0, 0, 0, 1, 0, 0, 0);
    chk("R4", "empty again", 32'(state_words[15:0]), 32'h0133);
  endtask

  task automatic t_underflow;
    cyc("R5", 0, 0, 0, 1, 1, 0, 0);
    chk("R5", "unf bit1", 32'(unf_flags), 32'h2);
    cyc("R7", 0, 0, 0, 0, 0, 0, 4'h2);
    chk("R7", "unf cleared", 32'(unf_flags), 32'h0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 16; i++) cyc("R3", 1, 2, 12'(12'h200 + i), 0, 0, 0, 0);
    chk("R3", "full word", 32'(state_words[47:32]), 32'h1000);
    cyc("R6", 1, 2, 12'hFFF, 0, 0, 0, 0);
    chk("R6", "ovf bit2", 32'(ovf_flags), 32'h4);
    cyc("R7", 0, 0, 0, 0, 0, 4'h4, 0);
    for (int i = 0; i < 16; i++) begin
      cyc("R4", 0, 0, 0, 1, 2, 0, 0);
      chk("R6", "order kept", 32'(pop_data), 32'(12'h200 + i));
    end
  endtask

  task automatic t_set_wins;
    cyc("R7", 0, 0, 0, 1, 3, 0, 0);
    cyc("R7", 0, 0, 0, 1, 3, 0, 4'h8);
    chk("R7", "set over clr", 32'(unf_flags), 32'h8);
    cyc("R7", 0, 0, 0, 0, 0, 0, 4'hF);
  endtask

  task automatic t_indep;
    cyc("R8", 1, 1, 12'h111, 0, 0, 0, 0);
    cyc("R8", 1, 3, 12'h333, 0, 0, 0, 0);
    cyc("R8", 1, 1, 12'h112, 1, 3, 0, 0);
    chk("R8", "lane3 data", 32'(pop_data), 32'h333);
    cyc("R8", 0, 0, 0, 1, 1, 0, 0);
    cyc("R8", 0, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_same_cycle;
    cyc("R9", 1, 0, 12'h501, 1, 0, 0, 0);
    cyc("R9", 1, 0, 12'h502, 1, 0, 0, 0);
    chk("R9", "passthrough", 32'(pop_data), 32'h501);
    cyc("R9", 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc("R9", 1, 0, 12'(12'h600 + i), 0, 0, 0, 0);
    cyc("R9", 1, 0, 12'h7FF, 1, 0, 0, 0);
    chk("R9", "full drop", 32'(ovf_flags), 32'h1);
    for (int i = 0; i < 15; i++) cyc("R9", 0, 0, 0, 1, 0, 0, 0);
    cyc("R9", 1, 0, 12'h777, 1, 0, 4'h1, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_underflow();
    t_full();
    t_set_wins();
    t_indep();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule